// File: doc/BRIEF.md
# Single-Precision Source and Result Modifier Stage

This stage sits on both sides of a floating-point execution unit in a vector datapath. On the way in, it rewrites the sign bit of up to three single-precision sources. Each source can have its sign cleared (absolute value), inverted (negate), or both. On the way out, it rewrites the exponent of the result to multiply it by 2, 4 or 0.5. It then optionally saturates the result into the unit interval.

The modifier fields come from the decoded long instruction format. A per-operation flag tells the stage whether the operation is floating point. When the flag is low, both paths pass their data through untouched. This covers integer and bitwise operations.

The source path and the result path are independent. Each has its own valid input and one register stage, so the output appears on the clock edge after the input is presented. The stage does no arithmetic beyond small exponent adjustments and comparisons.

Top module: `fpmod_stage`

## Requirements
- R1: When `src_is_fp_i` is 1 and bit i of `src_abs_i` is 1, the sign bit of source i is cleared before any negate. Bit 0 selects `src0_i`, bit 1 selects `src1_i` and bit 2 selects `src2_i`.
- R2: When `src_is_fp_i` is 1 and bit i of `src_neg_i` is 1, the sign bit of source i is inverted after the absolute-value step. Both bits set therefore gives sign 1, and negate alone gives the inverted input sign.
- R3: Bits 30:0 of every source pass unchanged. When `src_is_fp_i` is 0, all 32 bits of every source pass unchanged whatever the modifier fields hold.
- R4: The 2-bit `res_scale_i` field is encoded as 0 = no scaling, 1 = ×2, 2 = ×4 and 3 = ×0.5. Scaling changes only the exponent field (bits 30:23) by +1, +2 or −1, and keeps the sign and the mantissa (bits 22:0).
- R5: A scaled exponent that reaches 255 or more gives an infinity with the sign of the input (0x7F800000 or 0xFF800000).
- R6: A scaled exponent that falls to 0 or below gives a zero with the sign of the input. An input whose exponent field is 0 (zero or subnormal) also gives a zero with the input's sign.
- R7: Inputs whose exponent field is 255 (infinities and NaNs) pass through scaling unchanged.
- R8: When `res_clamp_i` is 1 on a floating-point result, the clamp is applied after scaling, with these outcomes:
  - NaN gives 0x00000000.
  - Any value with the sign bit set, including −0 and −infinity, gives 0x00000000.
  - Anything above 1.0 (0x3F800000), including +infinity, gives 0x3F800000.
  - Any other value is unchanged.
- R9: When `res_is_fp_i` is 0, `res_o` equals `res_i` regardless of `res_scale_i` and `res_clamp_i`.
- R10: Each output valid rises on the clock edge after its input valid is 1 and falls after a cycle with the input valid at 0. The output data holds its last value while no new valid input arrives. After reset, both valid outputs and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid_i | input | 1 | Source bundle is valid |
| src_is_fp_i | input | 1 | Current operation is floating point |
| src_abs_i | input | 3 | Absolute-value bit per source |
| src_neg_i | input | 3 | Negate bit per source |
| src0_i | input | 32 | Source 0 |
| src1_i | input | 32 | Source 1 |
| src2_i | input | 32 | Source 2 |
| opnd_valid_o | output | 1 | Modified sources are valid |
| opnd0_o | output | 32 | Modified source 0 |
| opnd1_o | output | 32 | Modified source 1 |
| opnd2_o | output | 32 | Modified source 2 |
| res_valid_i | input | 1 | Raw result is valid |
| res_is_fp_i | input | 1 | Result is floating point |
| res_scale_i | input | 2 | Output scale select |
| res_clamp_i | input | 1 | Clamp to [0.0, 1.0] |
| res_i | input | 32 | Raw result from the execution unit |
| res_valid_o | output | 1 | Final result is valid |
| res_o | output | 32 | Scaled and clamped result |

## Verification
The stage holds only one register per path, so any fault in the stage is visible on the very next output beat. A wrong sign rule appears as a flipped bit 31 on a source. A wrong exponent step shows up as a result off by a power of two, a missing overflow or underflow substitution, or a NaN whose payload has changed. A clamp placed before the scale, or one that ignores the sign, shows up as a result outside [0.0, 1.0] or as a value that was scaled after saturation. Bypass faults show as integer data with a modified bit 31 or a modified exponent.

// File: rtl/fpmod_pkg.sv
package fpmod_pkg;
  localparam int unsigned FP_EXP_W = 8;
  localparam int unsigned FP_MAN_W = 23;
  localparam int unsigned FP_W     = 1 + FP_EXP_W + FP_MAN_W;
  localparam int unsigned NUM_SRC  = 3;

  typedef enum logic [1:0] {
    SCALE_NONE = 2'd0,
    SCALE_X2   = 2'd1,
    SCALE_X4   = 2'd2,
    SCALE_HALF = 2'd3
  } scale_sel_e;
endpackage

// File: rtl/fpmod_src_lane.sv
module fpmod_src_lane #(
  parameter int unsigned W = 32
) (
  input  logic         is_fp,
  input  logic         abs_en,
  input  logic         neg_en,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  logic sign_abs;
  logic sign_fin;

  always_comb begin
    sign_abs = abs_en ? 1'b0 : val_i[W-1];
    sign_fin = sign_abs ^ neg_en;
    if (is_fp) begin
      val_o = {sign_fin, val_i[W-2:0]};
    end else begin
      val_o = val_i;
    end
  end
endmodule

// File: rtl/fpmod_scale.sv
module fpmod_scale
  import fpmod_pkg::*;
#(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                   is_fp,
  input  logic [1:0]             sel,
  input  logic [EXP_W+MAN_W:0]   val_i,
  output logic [EXP_W+MAN_W:0]   val_o
);
  localparam int unsigned AW = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_ALL1 = {EXP_W{1'b1}};

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic [AW-1:0]    delta;
  logic [AW-1:0]    ex_adj;
  logic             ovf;
  logic             unf;

  assign sgn = val_i[EXP_W+MAN_W];
  assign ex  = val_i[EXP_W+MAN_W-1:MAN_W];
  assign man = val_i[MAN_W-1:0];

  always_comb begin
    case (scale_sel_e'(sel))
      SCALE_X2:   delta = AW'(1);
      SCALE_X4:   delta = AW'(2);
      SCALE_HALF: delta = {AW{1'b1}};
      default:    delta = '0;
    endcase
    ex_adj = {2'b00, ex} + delta;
    ovf    = !ex_adj[AW-1] && (ex_adj[AW-2:0] >= {1'b0, EXP_ALL1});
    unf    = ex_adj[AW-1] || (ex_adj == '0);

    if (!is_fp || ex == EXP_ALL1) begin
      val_o = val_i;
    end else if (ex == '0) begin
      val_o = {sgn, {(EXP_W+MAN_W){1'b0}}};
    end else if (ovf) begin
      val_o = {sgn, EXP_ALL1, {MAN_W{1'b0}}};
    end else if (unf) begin
      val_o = {sgn, {(EXP_W+MAN_W){1'b0}}};
    end else begin
      val_o = {sgn, ex_adj[EXP_W-1:0], man};
    end
  end
endmodule

// File: rtl/fpmod_clamp.sv
module fpmod_clamp #(
  parameter int unsigned EXP_W = 8,
  parameter int unsigned MAN_W = 23
) (
  input  logic                 enable,
  input  logic [EXP_W+MAN_W:0] val_i,
  output logic [EXP_W+MAN_W:0] val_o
);
  localparam int unsigned W = 1 + EXP_W + MAN_W;
  localparam logic [W-1:0] ONE = {2'b00, {(EXP_W-1){1'b1}}, {MAN_W{1'b0}}};

  logic is_nan;
  logic is_neg;
  logic above;

  always_comb begin
    is_nan = (val_i[W-2:MAN_W] == {EXP_W{1'b1}}) && (val_i[MAN_W-1:0] != '0);
    is_neg = val_i[W-1];
    above  = {1'b0, val_i[W-2:0]} > ONE;
    if (!enable) begin
      val_o = val_i;
    end else if (is_nan || is_neg) begin
      val_o = '0;
    end else if (above) begin
      val_o = ONE;
    end else begin
      val_o = val_i;
    end
  end
endmodule

// File: rtl/fpmod_stage.sv
module fpmod_stage
  import fpmod_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        src_valid_i,
  input  logic        src_is_fp_i,
  input  logic [2:0]  src_abs_i,
  input  logic [2:0]  src_neg_i,
  input  logic [31:0] src0_i,
  input  logic [31:0] src1_i,
  input  logic [31:0] src2_i,
  output logic        opnd_valid_o,
  output logic [31:0] opnd0_o,
  output logic [31:0] opnd1_o,
  output logic [31:0] opnd2_o,
  input  logic        res_valid_i,
  input  logic        res_is_fp_i,
  input  logic [1:0]  res_scale_i,
  input  logic        res_clamp_i,
  input  logic [31:0] res_i,
  output logic        res_valid_o,
  output logic [31:0] res_o
);
  localparam int unsigned W = FP_W;

  logic [W-1:0] src_arr  [NUM_SRC];
  logic [W-1:0] mod_arr  [NUM_SRC];
  logic [W-1:0] opnd_q   [NUM_SRC];
  logic [W-1:0] opnd_d   [NUM_SRC];
  logic         opnd_vld_q;
  logic         opnd_vld_d;

  logic [W-1:0] scaled;
  logic [W-1:0] clamped;
  logic [W-1:0] res_q;
  logic [W-1:0] res_d;
  logic         res_vld_q;
  logic         res_vld_d;

  assign src_arr[0] = src0_i;
  assign src_arr[1] = src1_i;
  assign src_arr[2] = src2_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    fpmod_src_lane #(.W(W)) lane_i (
      .is_fp  (src_is_fp_i),
      .abs_en (src_abs_i[i]),
      .neg_en (src_neg_i[i]),
      .val_i  (src_arr[i]),
      .val_o  (mod_arr[i])
    );
  end

  fpmod_scale #(.EXP_W(FP_EXP_W), .MAN_W(FP_MAN_W)) scale_i (
    .is_fp (res_is_fp_i),
    .sel   (res_scale_i),
    .val_i (res_i),
    .val_o (scaled)
  );

  fpmod_clamp #(.EXP_W(FP_EXP_W), .MAN_W(FP_MAN_W)) clamp_i (
    .enable (res_clamp_i && res_is_fp_i),
    .val_i  (scaled),
    .val_o  (clamped)
  );

  always_comb begin
    opnd_vld_d = src_valid_i;
    for (int i = 0; i < NUM_SRC; i++) begin
      opnd_d[i] = src_valid_i ? mod_arr[i] : opnd_q[i];
    end
    res_vld_d = res_valid_i;
    res_d     = res_valid_i ? clamped : res_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opnd_vld_q <= 1'b0;
      res_vld_q  <= 1'b0;
      res_q      <= '0;
      for (int i = 0; i < NUM_SRC; i++) begin
        opnd_q[i] <= '0;
      end
    end else begin
      opnd_vld_q <= opnd_vld_d;
      res_vld_q  <= res_vld_d;
      res_q      <= res_d;
      for (int i = 0; i < NUM_SRC; i++) begin
        opnd_q[i] <= opnd_d[i];
      end
    end
  end

  assign opnd_valid_o = opnd_vld_q;
  assign opnd0_o      = opnd_q[0];
  assign opnd1_o      = opnd_q[1];
  assign opnd2_o      = opnd_q[2];
  assign res_valid_o  = res_vld_q;
  assign res_o        = res_q;
endmodule

// File: rtl/fpmod_stage_chk.sv
module fpmod_stage_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        src_valid_i,
  input logic        src_is_fp_i,
  input logic [2:0]  src_abs_i,
  input logic [2:0]  src_neg_i,
  input logic [31:0] src0_i,
  input logic [31:0] src1_i,
  input logic [31:0] src2_i,
  input logic        opnd_valid_o,
  input logic [31:0] opnd0_o,
  input logic [31:0] opnd1_o,
  input logic [31:0] opnd2_o,
  input logic        res_valid_i,
  input logic        res_is_fp_i,
  input logic [1:0]  res_scale_i,
  input logic        res_clamp_i,
  input logic [31:0] res_i,
  input logic        res_valid_o,
  input logic [31:0] res_o
);
  // R1 / R2: with the abs bit set, the final sign equals the negate bit
  p_abs_then_neg_r1: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid_i && src_is_fp_i && src_abs_i[0] |=> opnd0_o[31] == $past(src_neg_i[0]));

  // R3: magnitude bits of every source are untouched
  p_magnitude_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid_i |=> opnd1_o[30:0] == $past(src1_i[30:0]) && opnd2_o[30:0] == $past(src2_i[30:0]));

  // R3: integer operations pass sources verbatim
  p_int_src_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid_i && !src_is_fp_i |=> opnd0_o == $past(src0_i));

  // R9: integer results bypass scale and clamp
  p_int_res_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i && !res_is_fp_i |=> res_o == $past(res_i));

  // R8: clamped results land in [+0.0, 1.0]
  p_clamp_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i && res_is_fp_i && res_clamp_i |=> !res_o[31] && res_o[30:0] <= 31'h3F800000);

  // R7: infinities and NaNs are not rescaled
  p_special_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i && res_is_fp_i && !res_clamp_i && res_i[30:23] == 8'hFF |=> res_o == $past(res_i));

  // R10: valid outputs follow valid inputs by one cycle
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> opnd_valid_o == $past(src_valid_i) && res_valid_o == $past(res_valid_i));

  // R10: data holds without a new valid input
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid_i |=> $stable(res_o));
endmodule

bind fpmod_stage fpmod_stage_chk chk_i (.*);

// File: tb/fpmod_stage_tb_top.sv
module fpmod_stage_tb_top;
  logic        clk;
  logic        rst_n;
  logic        src_valid_i, src_is_fp_i;
  logic [2:0]  src_abs_i, src_neg_i;
  logic [31:0] src0_i, src1_i, src2_i;
  logic        opnd_valid_o;
  logic [31:0] opnd0_o, opnd1_o, opnd2_o;
  logic        res_valid_i, res_is_fp_i, res_clamp_i;
  logic [1:0]  res_scale_i;
  logic [31:0] res_i;
  logic        res_valid_o;
  logic [31:0] res_o;

  int n_checks = 0;
  int n_errors = 0;

  fpmod_stage dut_i (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_src(input logic fp, input logic a, input logic n,
                                          input logic [31:0] x);
    logic [31:0] y;
    y = x;
    if (fp) begin
      if (a) y[31] = 1'b0;
      if (n) y[31] = ~y[31];
    end
    return y;
  endfunction

  function automatic logic [31:0] ref_res(input logic fp, input logic [1:0] sc, input logic cl,
                                          input logic [31:0] x);
    int e;
    logic [31:0] y;
    if (!fp) return x;
    e = int'(x[30:23]);
    if (e == 255) y = x;
    else if (e == 0) y = {x[31], 31'd0};
    else begin
      e = e + (sc == 2'd1 ? 1 : sc == 2'd2 ? 2 : sc == 2'd3 ? -1 : 0);
      if (e >= 255) y = {x[31], 8'hFF, 23'd0};
      else if (e <= 0) y = {x[31], 31'd0};
      else y = {x[31], 8'(e), x[22:0]};
    end
    if (cl) begin
      if (y[30:23] == 8'hFF && y[22:0] != 0) y = 32'd0;
      else if (y[31]) y = 32'd0;
      else if (y > 32'h3F800000) y = 32'h3F800000;
    end
    return y;
  endfunction

  task automatic do_src(input logic fp, input logic [2:0] a, input logic [2:0] n,
                        input logic [31:0] s0, input logic [31:0] s1, input logic [31:0] s2,
                        input string req);
    @(negedge clk);
    src_valid_i = 1'b1; src_is_fp_i = fp; src_abs_i = a; src_neg_i = n;
    src0_i = s0; src1_i = s1; src2_i = s2;
    @(negedge clk);
    src_valid_i = 1'b0;
    check(req, {31'd0, opnd_valid_o}, 32'd1);
    check(req, opnd0_o, ref_src(fp, a[0], n[0], s0));
    check(req, opnd1_o, ref_src(fp, a[1], n[1], s1));
    check(req, opnd2_o, ref_src(fp, a[2], n[2], s2));
  endtask

  task automatic do_res(input logic fp, input logic [1:0] sc, input logic cl,
                        input logic [31:0] x, input logic [31:0] exp, input string req);
    @(negedge clk);
    res_valid_i = 1'b1; res_is_fp_i = fp; res_scale_i = sc; res_clamp_i = cl; res_i = x;
    @(negedge clk);
    res_valid_i = 1'b0;
    check(req, {31'd0, res_valid_o}, 32'd1);
    check(req, res_o, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    src_valid_i = 0; src_is_fp_i = 0; src_abs_i = 0; src_neg_i = 0;
    src0_i = 0; src1_i = 0; src2_i = 0;
    res_valid_i = 0; res_is_fp_i = 0; res_scale_i = 0; res_clamp_i = 0; res_i = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", {28'd0, opnd_valid_o, res_valid_o, 2'b00}, 32'd0);
    check("R10 reset", opnd0_o | opnd1_o | opnd2_o | res_o, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R2 directed
    do_src(1'b1, 3'b001, 3'b000, 32'hBF800000, 32'h3F800000, 32'hC0000000, "R1 abs only src0");
    check("R1", opnd0_o, 32'h3F800000);
    do_src(1'b1, 3'b111, 3'b101, 32'hBF800000, 32'hBF800000, 32'h3F800000, "R2 abs then neg");
    check("R2", opnd0_o, 32'hBF800000);
    check("R2", opnd1_o, 32'h3F800000);
    do_src(1'b1, 3'b000, 3'b110, 32'h3F800000, 32'h3F800000, 32'hBF800000, "R2 neg only");
    check("R2", opnd2_o, 32'h3F800000);
    // R3: integer bypass
    do_src(1'b0, 3'b111, 3'b111, 32'hFFFFFFFF, 32'h80000001, 32'h12345678, "R3 int bypass");
    check("R3", opnd0_o, 32'hFFFFFFFF);

    // R10: hold with valid low
    @(negedge clk);
    src0_i = 32'h0; src_is_fp_i = 1'b1;
    @(negedge clk);
    check("R10 hold", opnd0_o, 32'hFFFFFFFF);
    check("R10 valid drop", {31'd0, opnd_valid_o}, 32'd0);

    // R4..R9 directed
    do_res(1'b1, 2'd0, 1'b0, 32'h3FC00000, 32'h3FC00000, "R4 none");
    do_res(1'b1, 2'd1, 1'b0, 32'h3FC00000, 32'h40400000, "R4 x2");
    do_res(1'b1, 2'd2, 1'b0, 32'hBFC00000, 32'hC0C00000, "R4 x4");
    do_res(1'b1, 2'd3, 1'b0, 32'h3FC00000, 32'h3F400000, "R4 half");
    do_res(1'b1, 2'd1, 1'b0, 32'h7F7FFFFF, 32'h7F800000, "R5 overflow pos");
    do_res(1'b1, 2'd2, 1'b0, 32'hFF000001, 32'hFF800000, "R5 overflow neg");
    do_res(1'b1, 2'd3, 1'b0, 32'h80800000, 32'h80000000, "R6 underflow");
    do_res(1'b1, 2'd1, 1'b0, 32'h00400000, 32'h00000000, "R6 subnormal in");
    do_res(1'b1, 2'd2, 1'b0, 32'h80000000, 32'h80000000, "R6 neg zero");
    do_res(1'b1, 2'd2, 1'b0, 32'h7FC00001, 32'h7FC00001, "R7 nan");
    do_res(1'b1, 2'd3, 1'b0, 32'hFF800000, 32'hFF800000, "R7 inf");
    do_res(1'b1, 2'd1, 1'b1, 32'h3FC00000, 32'h3F800000, "R8 scale then clamp high");
    do_res(1'b1, 2'd1, 1'b1, 32'h3E800000, 32'h3F000000, "R8 scale then in range");
    do_res(1'b1, 2'd0, 1'b1, 32'h7FC00000, 32'h00000000, "R8 nan to zero");
    do_res(1'b1, 2'd0, 1'b1, 32'hC0000000, 32'h00000000, "R8 negative");
    do_res(1'b1, 2'd0, 1'b1, 32'h80000000, 32'h00000000, "R8 neg zero");
    do_res(1'b1, 2'd0, 1'b1, 32'h7F800000, 32'h3F800000, "R8 pos inf");
    do_res(1'b1, 2'd3, 1'b1, 32'h3F800000, 32'h3F000000, "R8 half of one");
    do_res(1'b0, 2'd1, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, "R9 int bypass");
    do_res(1'b0, 2'd3, 1'b1, 32'h7FC00000, 32'h7FC00000, "R9 int bypass");

    // random
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a0, a1, a2;
      logic fp;
      logic [2:0] ab, ng;
      a0 = $urandom; a1 = $urandom; a2 = $urandom;
      fp = 1'($urandom); ab = 3'($urandom); ng = 3'($urandom);
      do_src(fp, ab, ng, a0, a1, a2, "R1 R2 R3 random");
    end
    for (int k = 0; k < 300; k++) begin
      logic [31:0] x;
      logic fp, cl;
      logic [1:0] sc;
      x = $urandom;
      if (k % 4 == 0) x[30:23] = 8'($urandom_range(0, 3));
      if (k % 4 == 1) x[30:23] = 8'($urandom_range(252, 255));
      if (k % 4 == 2) x[30:23] = 8'($urandom_range(124, 128));
      fp = ($urandom_range(0, 7) != 0);
      cl = 1'($urandom); sc = 2'($urandom);
      do_res(fp, sc, cl, x, ref_res(fp, sc, cl, x), "R4 R5 R6 R7 R8 R9 random");
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule